// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an external 128K x 8 asynchronous static RAM. It turns a single-cycle host request (read or write, with a 17-bit address and a data byte) into a correctly timed sequence on the memory pins. The RAM has two chip selects of opposite polarity, an output enable, a write enable and a shared byte-wide data bus. Every pin is driven from a flop, and every timing is a whole number of clock cycles. Each count is worked out from a clock-period parameter and a nanosecond limit, rounded up.

A write is controlled by the write enable. The chip is selected, the write enable is pulled low with the output enable held high, the bus is driven before the end of the pulse, and address and data are held for one cycle after the write enable rises. A read selects the chip with the output enable low and captures the bus once the access time has passed. A retention input parks the device deselected so that the supply can be lowered. When the input is released, a recovery time equal to one read cycle must pass before any new access can begin.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is asserted, and on its release, `mem_cs1_no`=1, `mem_cs2_o`=0, `mem_oe_no`=1, `mem_we_no`=1, `mem_dq_oe_o`=0, `busy_o`=0 and `done_o`=0.
- R2: The device is selected (`mem_cs1_no`=0 together with `mem_cs2_o`=1) only during the active cycles of an accepted access. In every other cycle `mem_cs1_no`=1 and `mem_cs2_o`=0.
- R3: A read is accepted when `req_i`=1 and `we_i`=0 are sampled while idle. For RD_CYC cycles (default 2) the chip is selected with `mem_oe_no`=0, `mem_we_no`=1 and the bus not driven. `rdata_o` takes `mem_dq_i` at the clock edge that ends the last of these cycles.
- R4: A write is accepted when `req_i`=1 and `we_i`=1 are sampled while idle. For WP_CYC cycles (default 2) the chip is selected with `mem_we_no`=0 and `mem_oe_no`=1, and `mem_dq_oe_o`=1 in the last DW_CYC of those cycles (default 1). One further cycle follows with `mem_we_no`=1, the chip still selected and the bus still driven.
- R5: `mem_addr_o` (and, for a write, `mem_dq_o`) holds the values sampled at acceptance for every selected cycle of the access, even if the host inputs change.
- R6: `mem_dq_oe_o` and `mem_oe_no`=0 never coincide. The cycle after any cycle with `mem_dq_oe_o`=1 has `mem_oe_no`=1.
- R7: `busy_o`=1 from the cycle after acceptance up to the cycle before `done_o`. `done_o` is high for exactly one cycle, in which `busy_o`=0: the cycle after the last read cycle, or the cycle after the write hold cycle. Requests sampled while busy are ignored.
- R8: A request sampled in the `done_o` cycle is accepted, and its first selected cycle follows immediately.
- R9: `ret_i`=1 sampled while idle enters retention, and it wins over a request sampled on the same edge. In retention the device is deselected, `busy_o`=1, and requests are ignored.
- R10: After `ret_i`=0 is sampled in retention, `busy_o` stays 1 for RD_CYC more cycles (default 2), and requests sampled in that window are ignored. Idle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Host byte address |
| wdata_i | input | 8 | Host write data |
| ret_i | input | 1 | Retention request (level) |
| rdata_o | output | 8 | Last read data |
| busy_o | output | 1 | Access, retention or recovery in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | 17 | Memory address |
| mem_cs1_no | output | 1 | Chip select, active low |
| mem_cs2_o | output | 1 | Chip select, active high |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_dq_o | output | 8 | Data toward memory |
| mem_dq_oe_o | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 8 | Data from memory |

## Verification
Entry into retention and acceptance of a request can fall on the same idle edge. The bench raises `ret_i` and `req_i` together and expects no chip select in any later cycle, with busy held through retention and recovery. A request held high across the last recovery cycle and the first idle cycle is judged as well: no select may appear afterwards. Separately, a read issued in the done cycle of a write puts bus release and output enable in neighbouring cycles. The bench checks every cycle that a fully released cycle lies between them.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WR, ST_HOLD, ST_RET, ST_REC
  } seq_state_e;

  // ns limit -> whole cycles, rounded up, at least one
  function automatic int cyc_ceil(input int lim_ns, input int per_ns);
    int c;
    c = (lim_ns + per_ns - 1) / per_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (load_i)              cnt_d_o = load_val_i;
    else if (cnt_q != '0)    cnt_d_o = cnt_q - CNT_W'(1);
    else                     cnt_d_o = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d_o;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 2,
  parameter int RD_CYC  = 2,
  parameter int WP_CYC  = 2,
  parameter int REC_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             ret_i,
  input  logic             zero_i,
  output seq_state_e       state_d_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_state_e state_q;
  logic       done_d;

  always_comb begin
    state_d_o  = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ret_i) begin
          state_d_o = ST_RET;            // retention beats a same-edge request
        end else if (req_i) begin
          accept_o = 1'b1;
          load_o   = 1'b1;
          if (we_i) begin
            state_d_o  = ST_WR;
            load_val_o = CNT_W'(WP_CYC - 1);
          end else begin
            state_d_o  = ST_RD;
            load_val_o = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_RD: if (zero_i) begin
        state_d_o = ST_IDLE;
        capture_o = 1'b1;
        done_d    = 1'b1;
      end
      ST_WR:   if (zero_i) state_d_o = ST_HOLD;
      ST_HOLD: begin
        state_d_o = ST_IDLE;
        done_d    = 1'b1;
      end
      ST_RET: if (!ret_i) begin
        state_d_o  = ST_REC;
        load_o     = 1'b1;
        load_val_o = CNT_W'(REC_CYC - 1);
      end
      ST_REC:  if (zero_i) state_d_o = ST_IDLE;
      default: state_d_o = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d_o;
      done_o  <= done_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 2,
  parameter int DW_CYC = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_state_e        state_d_i,
  input  logic [CNT_W-1:0]  cnt_d_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs1_no,
  output logic              mem_cs2_o,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o
);
  logic sel_d, drv_d;

  assign sel_d = (state_d_i == ST_RD) || (state_d_i == ST_WR) || (state_d_i == ST_HOLD);
  // drive only in the tail of the WE pulse and through the hold cycle
  assign drv_d = ((state_d_i == ST_WR) && (cnt_d_i < CNT_W'(DW_CYC))) ||
                 (state_d_i == ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_cs1_no  <= 1'b1;
      mem_cs2_o   <= 1'b0;
      mem_oe_no   <= 1'b1;
      mem_we_no   <= 1'b1;
      mem_dq_oe_o <= 1'b0;
      mem_addr_o  <= '0;
      mem_dq_o    <= '0;
      rdata_o     <= '0;
    end else begin
      mem_cs1_no  <= !sel_d;
      mem_cs2_o   <= sel_d;
      mem_oe_no   <= (state_d_i != ST_RD);
      mem_we_no   <= (state_d_i != ST_WR);
      mem_dq_oe_o <= drv_d;
      if (accept_i) begin
        mem_addr_o <= addr_i;
        mem_dq_o   <= wdata_i;
      end
      if (capture_i) rdata_o <= mem_dq_i;
    end
  end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 20,
  parameter int T_WP_NS       = 15,
  parameter int T_DW_NS       = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ret_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs1_no,
  output logic              mem_cs2_o,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int RD_CYC  = cyc_ceil(T_RC_NS, CLK_PERIOD_NS);
  localparam int WP_CYC  = cyc_ceil(T_WP_NS, CLK_PERIOD_NS);
  localparam int DW_RAW  = cyc_ceil(T_DW_NS, CLK_PERIOD_NS);
  localparam int DW_CYC  = (DW_RAW > WP_CYC) ? WP_CYC : DW_RAW;
  localparam int REC_CYC = RD_CYC;
  localparam int MAX_CYC = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;

  seq_state_e       state_d;
  logic             load, accept, capture, zero;
  logic [CNT_W-1:0] load_val, cnt_d;

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .load_i(load), .load_val_i(load_val),
    .cnt_d_o(cnt_d), .zero_o(zero)
  );

  sram_ctrl_seq #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .REC_CYC(REC_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .req_i, .we_i, .ret_i,
    .zero_i(zero), .state_d_o(state_d),
    .load_o(load), .load_val_o(load_val),
    .accept_o(accept), .capture_o(capture),
    .busy_o, .done_o
  );

  sram_ctrl_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DW_CYC(DW_CYC)
  ) u_pins (
    .clk_i, .rst_ni,
    .state_d_i(state_d), .cnt_d_i(cnt_d),
    .accept_i(accept), .capture_i(capture),
    .addr_i, .wdata_i, .mem_dq_i, .rdata_o,
    .mem_addr_o, .mem_cs1_no, .mem_cs2_o, .mem_oe_no, .mem_we_no,
    .mem_dq_o, .mem_dq_oe_o
  );
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs1_no,
  input logic              mem_cs2_o,
  input logic              mem_oe_no,
  input logic              mem_we_no,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);
  p_sel_pair_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_cs1_no != mem_cs2_o);

  p_we_selected_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_cs1_no && mem_oe_no));

  p_read_no_drive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (!mem_cs1_no && mem_we_no));

  p_no_contention_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_no));

  p_turnaround_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |=> mem_oe_no);

  p_addr_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs1_no && $past(!mem_cs1_no)) |-> $stable(mem_addr_o));

  p_data_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_not_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_sram_cycle_ctrl.sv
module sim_sram_cycle_ctrl;
  localparam int AW = 17;
  localparam int DW = 8;

  typedef struct {
    bit             sel, oe_n, we_n, dq_oe, busy, done, chk_rd;
    logic [DW-1:0]  rd;
    logic [AW-1:0]  addr;
    logic [DW-1:0]  dq;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0, ret = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, mem_dq_o, mem_dq_i = '0;
  logic [AW-1:0] mem_addr;
  logic busy, done, cs1_n, cs2, oe_n, we_n, dq_oe;

  always #10 clk = ~clk;

  sram_cycle_ctrl u0 (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ret_i(ret), .rdata_o(rdata), .busy_o(busy), .done_o(done),
    .mem_addr_o(mem_addr), .mem_cs1_no(cs1_n), .mem_cs2_o(cs2), .mem_oe_no(oe_n),
    .mem_we_no(we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(mem_dq_i)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  exp_t q[$];
  logic [DW-1:0] sram_arr [int];
  logic [DW-1:0] ref_arr [int];
  bit prev_dq_oe = 0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", r, act, expv, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // behavioural memory on the pins
  always @(negedge clk) begin
    if (!cs1_n && cs2 && !we_n && dq_oe) sram_arr[int'(mem_addr)] = mem_dq_o;
    if (!cs1_n && cs2 && !oe_n)
      mem_dq_i <= sram_arr.exists(int'(mem_addr)) ? sram_arr[int'(mem_addr)] : '0;
    else
      mem_dq_i <= '0;
  end

  // per-cycle comparison against the expectation queue
  always @(posedge clk) begin
    #5;
    if (rst_ni && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk("R2 cs1_n", 32'(cs1_n), 32'(!e.sel));
      chk("R2 cs2", 32'(cs2), 32'(e.sel));
      chk("R3 oe_n", 32'(oe_n), 32'(e.oe_n));
      chk("R4 we_n", 32'(we_n), 32'(e.we_n));
      chk("R4 dq_oe", 32'(dq_oe), 32'(e.dq_oe));
      chk("R7 busy", 32'(busy), 32'(e.busy));
      chk("R7 done", 32'(done), 32'(e.done));
      if (e.sel)   chk("R5 addr", 32'(mem_addr), 32'(e.addr));
      if (e.dq_oe) chk("R5 wdata", 32'(mem_dq_o), 32'(e.dq));
      if (e.chk_rd) chk("R3 rdata", 32'(rdata), 32'(e.rd));
      chk("R6 contention", 32'(dq_oe && !oe_n), 32'(0));
      chk("R6 turnaround", 32'(prev_dq_oe && !oe_n), 32'(0));
      prev_dq_oe = dq_oe;
    end
  end

  function automatic exp_t idle_e(input bit b, input bit d);
    exp_t e;
    e = '{sel:0, oe_n:1, we_n:1, dq_oe:0, busy:b, done:d, chk_rd:0, rd:'0, addr:'0, dq:'0};
    return e;
  endfunction

  function automatic exp_t act_e(input bit o, input bit w, input bit dr,
                                 input logic [AW-1:0] a, input logic [DW-1:0] d);
    exp_t e;
    e = '{sel:1, oe_n:o, we_n:w, dq_oe:dr, busy:1, done:0, chk_rd:0, rd:'0, addr:a, dq:d};
    return e;
  endfunction

  task automatic cyc(input exp_t e);
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req = 0; ret = 0;
    repeat (n) cyc(idle_e(0, 0));
  endtask

  // R3 read: two selected cycles, done with data in the third
  task automatic do_read(input logic [AW-1:0] a, input bit hold);
    exp_t e;
    req = 1; we = 0; addr = a;
    cyc(act_e(0, 1, 0, a, '0));
    if (hold) addr = ~a; else req = 0;       // R7 held request ignored
    cyc(act_e(0, 1, 0, a, '0));
    req = 0;
    e = idle_e(0, 1);
    e.chk_rd = 1;
    e.rd = ref_arr.exists(int'(a)) ? ref_arr[int'(a)] : '0;
    cyc(e);
  endtask

  // R4 write: WE low two cycles, data in the second, hold cycle, done
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit hold);
    req = 1; we = 1; addr = a; wdata = d;
    ref_arr[int'(a)] = d;
    cyc(act_e(1, 0, 0, a, d));
    if (hold) begin addr = ~a; wdata = ~d; end else req = 0;
    cyc(act_e(1, 0, 1, a, d));
    cyc(act_e(1, 1, 1, a, d));
    req = 0;
    cyc(idle_e(0, 1));
  endtask

  // R9/R10 retention with optional same-edge request
  task automatic ret_seq(input int k, input bit collide);
    ret = 1; req = collide; we = 1; addr = 17'h00155; wdata = 8'hEE;
    cyc(idle_e(1, 0));
    for (int i = 1; i < k; i++) begin
      req = ~req;
      cyc(idle_e(1, 0));
    end
    ret = 0; req = 0;
    cyc(idle_e(1, 0));                      // R10 first recovery cycle
    req = 1; we = 0;
    cyc(idle_e(1, 0));                      // R10 second, request ignored
    cyc(idle_e(0, 0));                      // R10 idle; request sampled in recovery
    req = 0;
    cyc(idle_e(0, 0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog act=running exp=finished");
    summary();
  end

  initial begin
    #25;
    // R1 reset state
    chk("R1 cs1_n", 32'(cs1_n), 32'(1));
    chk("R1 cs2", 32'(cs2), 32'(0));
    chk("R1 oe_n", 32'(oe_n), 32'(1));
    chk("R1 we_n", 32'(we_n), 32'(1));
    chk("R1 dq_oe", 32'(dq_oe), 32'(0));
    chk("R1 busy", 32'(busy), 32'(0));
    chk("R1 done", 32'(done), 32'(0));
    @(negedge clk);
    rst_ni = 1;
    idle(2);

    do_write(17'h00010, 8'hA5, 0);
    idle(1);
    do_read(17'h00010, 0);
    idle(1);
    // R8 back-to-back, address extremes
    do_write(17'h1FFFF, 8'h3C, 0);
    do_write(17'h00000, 8'hC3, 0);
    do_read(17'h1FFFF, 0);
    do_read(17'h00000, 0);
    // R6 read issued in the write's done cycle
    do_write(17'h0ABCD, 8'h5A, 0);
    do_read(17'h0ABCD, 0);
    // R7 requests while busy are ignored; R5 inputs change mid-access
    do_write(17'h12345, 8'h77, 1);
    idle(1);
    do_read(~17'h12345, 0);
    do_read(17'h12345, 1);
    idle(1);
    for (int i = 0; i < 8; i++) do_write(17'((i * 4099 + 7) % 131072), 8'(i * 37 + 1), 0);
    for (int i = 7; i >= 0; i--) do_read(17'((i * 4099 + 7) % 131072), 0);
    // R9 retention alone, then with a colliding request
    idle(1);
    ret_seq(3, 0);
    do_read(17'h00010, 0);
    ret_seq(2, 1);
    do_read(17'h00155, 0);                  // R9 colliding write never happened
    do_write(17'h00155, 8'h42, 0);
    do_read(17'h00155, 0);
    idle(3);
    @(posedge clk);
    #8;
    summary();
  end
endmodule